// File: doc/BRIEF.md
# Majority Coincidence Trigger Unit

This block turns the sample streams of several input channels into one board-wide acquisition trigger. Each channel compares its current sample against its own threshold. A polarity bit selects whether the sample must rise above the threshold or fall below it. When a channel first enters the beyond-threshold region it produces a one-cycle crossing pulse. That pulse is then held active for a programmable number of extra cycles, the coincidence window.

With coincidence mode on, the unit counts the enabled channels whose stretched pulse is active. It asserts its condition when that count is strictly greater than the programmed majority level. With coincidence mode off, any enabled crossing is enough. An external trigger input either adds to the channel sources or, in gate mode, qualifies them. A software trigger always passes through. Every channel acquires on the resulting common trigger, which is a single-cycle pulse issued on each rising edge of the combined condition.

Top module: `mct_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `trig_o` is low. All crossing history, window counters and the previous-condition state clear to zero.
- R2: A channel with polarity bit 1 is beyond its threshold when sample > threshold (unsigned, strict). With polarity bit 0 it is beyond when sample < threshold. A crossing is flagged only in a cycle where the channel is beyond and was not beyond in the previous cycle. After reset the previous state counts as "not beyond".
- R3: A channel whose bit in `chan_en_i` is 0 never contributes to the trigger condition, in either coincidence mode.
- R4: A crossing makes the channel active in that cycle and in the following `win_len_i` cycles, so it is active for 1 + window cycles. A new crossing restarts the window. With window 0, a channel is active only in the cycle of its crossing.
- R5: With `coinc_en_i` = 1, the channel condition is true when the number of enabled active channels is strictly greater than `maj_lvl_i`.
- R6: With `coinc_en_i` = 0, the channel condition is true in any cycle in which at least one enabled channel flags a crossing. The window is not used.
- R7: With `gate_mode_i` = 0, `ext_trig_i` high makes the condition true on its own. With `gate_mode_i` = 1, the condition is the channel condition AND `ext_trig_i`.
- R8: `sw_trig_i` high makes the combined condition true regardless of gate mode and of `ext_trig_i`.
- R9: `trig_o` is high for exactly one cycle, in the cycle after the combined condition is true while it was false in the cycle before. A condition that stays true produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_i | input | NCH*SW | Current sample of every channel, channel c at bits [c*SW +: SW] |
| thr_i | input | NCH*SW | Per-channel threshold, same packing |
| pol_i | input | NCH | Per-channel polarity: 1 over, 0 under |
| chan_en_i | input | NCH | Per-channel enable mask |
| coinc_en_i | input | 1 | 1 selects majority counting over stretched pulses |
| maj_lvl_i | input | CW | Majority level; count must exceed it |
| win_len_i | input | WW | Coincidence window in extra cycles |
| ext_trig_i | input | 1 | External trigger or gate input |
| gate_mode_i | input | 1 | 1 makes the external input a gate |
| sw_trig_i | input | 1 | Software trigger, never gated |
| trig_o | output | 1 | Single-cycle board trigger |

## Verification
Random samples jitter around each threshold with random polarities, so crossings, re-crossings and sustained beyond-threshold stretches all occur. This separates edge detection from level detection. Random majority levels, windows and masks are tried with coincidence mode on and off. These runs show whether the count uses stretched or raw pulses, a strict or non-strict comparison, and the enable mask. Directed sequences with a zero window place two crossings in the same cycle and in adjacent cycles, which tells same-cycle coincidence apart from overlap. Gate-mode runs toggle the external and software inputs independently, which shows that the gate applies to every source except the software trigger.

// File: rtl/mct_pkg.sv
package mct_pkg;
  typedef enum logic {
    POL_UNDER = 1'b0,
    POL_OVER  = 1'b1
  } pol_e;
endpackage

// File: rtl/mct_cross_det.sv
module mct_cross_det
  import mct_pkg::*;
#(
  parameter int SW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] samp_i,
  input  logic [SW-1:0] thr_i,
  input  logic          pol_i,
  output logic          xing_o
);
  logic beyond;
  logic prev_q;
  logic prev_nx;

  always_comb begin
    if (pol_e'(pol_i) == POL_OVER) beyond = (samp_i > thr_i);
    else                           beyond = (samp_i < thr_i);
  end

  always_comb prev_nx = beyond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_nx;
  end

  assign xing_o = beyond & ~prev_q;

  AST_XING_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    xing_o |=> !xing_o); // R2
endmodule

// File: rtl/mct_stretch.sv
module mct_stretch #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xing_i,
  input  logic [WW-1:0] win_i,
  output logic          active_o
);
  logic [WW-1:0] cnt_q;
  logic [WW-1:0] cnt_nx;
  logic          cnt_busy;

  assign cnt_busy = (cnt_q != '0);

  always_comb begin
    cnt_nx = cnt_q;
    if (xing_i)        cnt_nx = win_i;
    else if (cnt_busy) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign active_o = xing_i | cnt_busy;

  AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_busy && !xing_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xing_i && win_i != '0) |=> active_o); // R4
endmodule

// File: rtl/mct_decide.sv
module mct_decide #(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] active_i,
  input  logic [NCH-1:0] xing_i,
  input  logic [NCH-1:0] en_i,
  input  logic           coinc_en_i,
  input  logic [CW-1:0]  maj_i,
  input  logic           ext_i,
  input  logic           gate_i,
  input  logic           sw_i,
  output logic           trig_o
);
  logic [CW-1:0] hits;
  logic          chan_cond;
  logic          src_cond;
  logic          cond;
  logic          cond_q;
  logic          cond_nx;
  logic          trig_q;
  logic          trig_nx;

  always_comb begin
    hits = '0;
    for (int c = 0; c < NCH; c++) begin
      if (active_i[c] && en_i[c]) hits = hits + 1'b1;
    end
  end

  always_comb begin
    if (coinc_en_i) chan_cond = (hits > maj_i);
    else            chan_cond = |(xing_i & en_i);
    if (gate_i) src_cond = chan_cond & ext_i;
    else        src_cond = chan_cond | ext_i;
    cond = src_cond | sw_i;
  end

  always_comb begin
    cond_nx = cond;
    trig_nx = cond & ~cond_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cond_q <= cond_nx;
      trig_q <= trig_nx;
    end
  end

  assign trig_o = trig_q;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o); // R9
  AST_SW_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_i && !cond_q) |=> trig_o); // R8
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i && !ext_i && !sw_i) |=> !trig_o); // R7
endmodule

// File: rtl/mct_top.sv
module mct_top #(
  parameter int NCH = 4,
  parameter int SW  = 14,
  parameter int WW  = 8,
  parameter int CW  = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] samp_i,
  input  logic [NCH*SW-1:0] thr_i,
  input  logic [NCH-1:0]    pol_i,
  input  logic [NCH-1:0]    chan_en_i,
  input  logic              coinc_en_i,
  input  logic [CW-1:0]     maj_lvl_i,
  input  logic [WW-1:0]     win_len_i,
  input  logic              ext_trig_i,
  input  logic              gate_mode_i,
  input  logic              sw_trig_i,
  output logic              trig_o
);
  logic [NCH-1:0] xing;
  logic [NCH-1:0] active;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mct_cross_det #(.SW(SW)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .samp_i (samp_i[c*SW +: SW]),
      .thr_i  (thr_i[c*SW +: SW]),
      .pol_i  (pol_i[c]),
      .xing_o (xing[c])
    );
    mct_stretch #(.WW(WW)) u_str (
      .clk      (clk),
      .rst_n    (rst_n),
      .xing_i   (xing[c]),
      .win_i    (win_len_i),
      .active_o (active[c])
    );
  end

  mct_decide #(.NCH(NCH), .CW(CW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .xing_i     (xing),
    .en_i       (chan_en_i),
    .coinc_en_i (coinc_en_i),
    .maj_i      (maj_lvl_i),
    .ext_i      (ext_trig_i),
    .gate_i     (gate_mode_i),
    .sw_i       (sw_trig_i),
    .trig_o     (trig_o)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en_i == '0 && !ext_trig_i && !sw_trig_i) |=> !trig_o); // R3
endmodule

// File: tb/tb_mct_top.sv
module tb_mct_top;
  localparam int NCH = 4;
  localparam int SW  = 14;
  localparam int WW  = 8;
  localparam int CW  = $clog2(NCH + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH*SW-1:0] samp;
  logic [NCH*SW-1:0] thr;
  logic [NCH-1:0]    pol;
  logic [NCH-1:0]    en;
  logic              coinc;
  logic [CW-1:0]     maj;
  logic [WW-1:0]     win;
  logic              ext;
  logic              gate;
  logic              sw;
  logic              trig_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  bit  m_prev [NCH];
  int  m_cnt  [NCH];
  bit  m_pc;

  always #4 clk = ~clk;

  mct_top #(.NCH(NCH), .SW(SW), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .thr_i(thr), .pol_i(pol),
    .chan_en_i(en), .coinc_en_i(coinc), .maj_lvl_i(maj), .win_len_i(win),
    .ext_trig_i(ext), .gate_mode_i(gate), .sw_trig_i(sw), .trig_o(trig_o)
  );

  task automatic check(string tag, bit exp);
    n_cmp++;
    if (trig_o !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_o=%0b expected %0b at %0t", tag, trig_o, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_prev[c] = 0;
      m_cnt[c]  = 0;
    end
    m_pc = 0;
  endtask

  function automatic bit is_beyond(int c);
    logic [SW-1:0] s;
    logic [SW-1:0] t;
    s = samp[c*SW +: SW];
    t = thr[c*SW +: SW];
    return pol[c] ? (s > t) : (s < t);
  endfunction

  // Expected trigger one cycle after the current inputs; updates model state.
  function automatic bit model_step();
    bit x [NCH];
    bit b [NCH];
    int hits = 0;
    bit anyx = 0;
    bit chc, cond, e;
    for (int c = 0; c < NCH; c++) begin
      b[c] = is_beyond(c);
      x[c] = b[c] && !m_prev[c];
      if (en[c] && (x[c] || m_cnt[c] != 0)) hits++;
      if (en[c] && x[c]) anyx = 1;
    end
    chc  = coinc ? (hits > int'(maj)) : anyx;
    cond = gate ? (chc && ext) : (chc || ext);
    cond = cond || sw;
    e = cond && !m_pc;
    for (int c = 0; c < NCH; c++) begin
      m_prev[c] = b[c];
      if (x[c])              m_cnt[c] = int'(win);
      else if (m_cnt[c] > 0) m_cnt[c] = m_cnt[c] - 1;
    end
    m_pc = cond;
    return e;
  endfunction

  task automatic step(string tag);
    bit e;
    e = model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, e);
  endtask

  task automatic rand_samples();
    for (int c = 0; c < NCH; c++)
      samp[c*SW +: SW] = SW'($urandom_range(994, 1006));
  endtask

  task automatic set_all(int v);
    for (int c = 0; c < NCH; c++) samp[c*SW +: SW] = SW'(v);
  endtask

  task automatic rand_phase(string tag, int n, bit c_en, bit g_mode,
                            bit rnd_ext, bit rnd_sw, bit rnd_en);
    for (int i = 0; i < n; i++) begin
      rand_samples();
      coinc = c_en;
      gate  = g_mode;
      if (i % 16 == 0) begin
        pol = NCH'($urandom);
        maj = CW'($urandom_range(0, NCH - 1));
        win = WW'($urandom_range(0, 5));
        en  = rnd_en ? NCH'($urandom) : '1;
      end
      ext = rnd_ext ? ($urandom_range(0, 3) == 0) : 1'b0;
      sw  = rnd_sw  ? ($urandom_range(0, 9) == 0) : 1'b0;
      step(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    for (int c = 0; c < NCH; c++) thr[c*SW +: SW] = SW'(1000);
    set_all(500);
    pol = '1; en = '1; coinc = 0; maj = '0; win = '0;
    ext = 0; gate = 0; sw = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rst_n = 1;
    step("R1 after release");

    // R2: polarity and edge-only crossing, coincidence off
    rand_phase("R2", 400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R6: any enabled crossing, masked channels
    rand_phase("R6", 400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R5: majority with random windows
    rand_phase("R5", 800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: majority with random masks
    rand_phase("R3", 600, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    // R7: external source then gate
    rand_phase("R7", 400, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    rand_phase("R7", 600, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R8: software trigger through the gate
    rand_phase("R8", 600, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);

    // R4: window 0, two crossings in the same cycle -> trigger
    pol = '1; en = '1; coinc = 1; maj = CW'(1); win = '0;
    ext = 0; gate = 0; sw = 0;
    set_all(500); step("R4");
    samp[0 +: SW] = SW'(1200); samp[SW +: SW] = SW'(1200); step("R4 same cycle");
    set_all(500); step("R4");
    // adjacent cycles with window 0 -> no trigger
    samp[0 +: SW] = SW'(1200); step("R4 first only");
    samp[SW +: SW] = SW'(1200); step("R4 adjacent, window 0");
    set_all(500); step("R4");
    // window 1 lets adjacent crossings overlap
    win = WW'(1);
    samp[0 +: SW] = SW'(1200); step("R4 first only");
    samp[SW +: SW] = SW'(1200); step("R4 adjacent, window 1");
    set_all(500); step("R4");
    // R2: equal to threshold is not beyond
    coinc = 0; win = '0;
    samp[0 +: SW] = SW'(1000); step("R2 equal");
    // R9: sustained condition gives one pulse
    sw = 1; step("R9 rise");
    step("R9 held");
    step("R9 held");
    sw = 0; step("R9 drop");
    sw = 1; step("R9 rise again");
    sw = 0; step("R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule